// File: doc/BRIEF.md
# NAND Streamed Transfer Counter and Interrupt Unit

This block sits beside a NAND controller's data path and keeps the bookkeeping for one streamed page transfer. Software loads a byte count, picks a direction and options, and sets a run bit. Each byte that the streaming engine moves lowers the count by one. When the count hits zero during a run, a completion event is latched.

A second event source watches the device ready line and latches on each rising edge. Both events share one two-bit interrupt group. The group has a latched status, an enable mask, a software set and a write-one-to-clear path. The interrupt line is the OR of every latched bit that is also enabled. The block also shows the current ready level and the empty/non-empty state of the two FIFOs on the data path as a small status word.

The NAND bus cycles and the ECC arithmetic belong to other blocks. Here only the control bits, the count and the flags are produced.

Top module: `nand_xfer_irq`

## Requirements
- R1: After reset, run, direction, burst, ECC enable, count, interrupt status, interrupt enable and irq are all 0.
- R2: A write strobe on `reg_wr[2]` loads `xfer_count` from `reg_wdata` and takes priority over counting. While running, each cycle with `byte_moved` high lowers the count by one. At zero the count stays at zero.
- R3: A write on `reg_wr[0]` sets `xfer_run` to `reg_wdata[0]`, and writing 0 stops the transfer. While `xfer_run` is 0, `byte_moved` leaves the count unchanged.
- R4: A write on `reg_wr[1]` sets `xfer_dir` from bit 1 (0 means write to the device, 1 means read from it), `xfer_burst` from bit 2 and `xfer_ecc` from bit 4. The other bits have no effect.
- R5: `status` bit 2 follows `strm_fifo_nempty`, bit 1 follows `byte_fifo_nempty` and bit 0 follows `dev_ready`, all in the same cycle.
- R6: `int_raw` bit 1 (transfer done) is set on the edge where a running count steps from 1 to 0. Loading 0 does not set it.
- R7: `int_raw` bit 0 (device ready) is set on the edge after `dev_ready` rises from a sampled low. A steady high level does not set it again after it has been cleared.
- R8: `irq` is high exactly when some bit of `int_raw` AND `int_en` is 1. `int_en` is loaded through `reg_wr[3]` from `reg_wdata[1:0]`.
- R9: A strobe on `reg_wr[4]` sets the `int_raw` bits that are 1 in `reg_wdata[1:0]`. A strobe on `reg_wr[5]` clears them. When both strobes occur in the same cycle, set wins.
- R10: A hardware event in the same cycle as a clear of its bit leaves that bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 6 | One write strobe per register: 0 control, 1 config, 2 count, 3 enable, 4 set, 5 clear |
| reg_wdata | input | CNT_W | Write data shared by all strobes |
| byte_moved | input | 1 | One byte moved on the stream path this cycle |
| dev_ready | input | 1 | Device ready line |
| strm_fifo_nempty | input | 1 | Streaming FIFO holds data |
| byte_fifo_nempty | input | 1 | Internal byte FIFO holds data |
| xfer_run | output | 1 | Transfer running |
| xfer_dir | output | 1 | Direction, 1 means read from device |
| xfer_burst | output | 1 | Burst transfers enabled |
| xfer_ecc | output | 1 | ECC enabled on the streamed path |
| xfer_count | output | CNT_W | Remaining byte count |
| status | output | 3 | {stream FIFO, byte FIFO, ready} |
| int_raw | output | 2 | Latched events {done, ready} |
| int_en | output | 2 | Interrupt enable mask |
| irq | output | 1 | Interrupt request |

## Verification
Counts from 1 to 6 are each run down byte by byte. This shows whether the done flag comes exactly at the step to zero, and not one step early or late, and whether an extra byte wraps the count. All 32 config values separate the three kept bits from the ignored ones. All 16 combinations of latched status and enable mask separate a correct OR-of-AND from a stuck or inverted mask term. Every preset and write pattern is also applied through set, clear and simultaneous set-plus-clear, which exposes a wrong priority. Ready edges are checked against a steady high level and against a clear in the same cycle, so an edge detector can be told apart from a level detector.

// File: rtl/nand_xfer_irq.sv
module nand_xfer_irq #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       reg_wr,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic             byte_moved,
  input  logic             dev_ready,
  input  logic             strm_fifo_nempty,
  input  logic             byte_fifo_nempty,
  output logic             xfer_run,
  output logic             xfer_dir,
  output logic             xfer_burst,
  output logic             xfer_ecc,
  output logic [CNT_W-1:0] xfer_count,
  output logic [2:0]       status,
  output logic [1:0]       int_raw,
  output logic [1:0]       int_en,
  output logic             irq
);
  localparam int W_CTRL = 0;
  localparam int W_CFG  = 1;
  localparam int W_CNT  = 2;
  localparam int W_IEN  = 3;
  localparam int W_SET  = 4;
  localparam int W_CLR  = 5;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic       rdy_q;
  logic       step;
  logic [1:0] hw_ev, set_v, clr_v, raw_next;

  assign step     = xfer_run && byte_moved && (xfer_count != '0) && !reg_wr[W_CNT];
  assign hw_ev    = {step && (xfer_count == ONE), dev_ready && !rdy_q};
  assign set_v    = reg_wr[W_SET] ? reg_wdata[1:0] : 2'b00;
  assign clr_v    = reg_wr[W_CLR] ? reg_wdata[1:0] : 2'b00;
  assign raw_next = (int_raw & ~clr_v) | set_v | hw_ev;
  assign status   = {strm_fifo_nempty, byte_fifo_nempty, dev_ready};
  assign irq      = |(int_raw & int_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_run   <= 1'b0;
      xfer_dir   <= 1'b0;
      xfer_burst <= 1'b0;
      xfer_ecc   <= 1'b0;
      xfer_count <= '0;
      int_raw    <= 2'b00;
      int_en     <= 2'b00;
      rdy_q      <= 1'b1;
    end else begin
      if (reg_wr[W_CTRL]) xfer_run <= reg_wdata[0];
      if (reg_wr[W_CFG]) begin
        xfer_dir   <= reg_wdata[1];
        xfer_burst <= reg_wdata[2];
        xfer_ecc   <= reg_wdata[4];
      end
      if (reg_wr[W_CNT])  xfer_count <= reg_wdata;
      else if (step)      xfer_count <= xfer_count - ONE;
      if (reg_wr[W_IEN])  int_en <= reg_wdata[1:0];
      rdy_q   <= dev_ready;
      int_raw <= raw_next;
    end
  end

  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_run && byte_moved && xfer_count != '0 && !reg_wr[W_CNT])
      |=> (xfer_count == $past(xfer_count) - ONE));

  a_r2_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_count == '0 && !reg_wr[W_CNT]) |=> (xfer_count == '0));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_run && !reg_wr[W_CNT]) |=> $stable(xfer_count));

  a_r6_done_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_run && byte_moved && xfer_count == ONE && !reg_wr[W_CNT]) |=> int_raw[1]);

  a_r7_ready_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ready && !rdy_q) |=> int_raw[0]);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr[W_SET] |=> ((int_raw & $past(reg_wdata[1:0])) == $past(reg_wdata[1:0])));
endmodule

// File: tb/nand_xfer_irq_tb_top.sv
module nand_xfer_irq_tb_top;
  localparam int CW = 12;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] reg_wr = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic byte_moved = 1'b0, dev_ready = 1'b0, strm_fifo_nempty = 1'b0, byte_fifo_nempty = 1'b0;
  logic xfer_run, xfer_dir, xfer_burst, xfer_ecc, irq;
  logic [CW-1:0] xfer_count;
  logic [2:0] status;
  logic [1:0] int_raw, int_en;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  nand_xfer_irq #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .byte_moved(byte_moved), .dev_ready(dev_ready),
    .strm_fifo_nempty(strm_fifo_nempty), .byte_fifo_nempty(byte_fifo_nempty),
    .xfer_run(xfer_run), .xfer_dir(xfer_dir), .xfer_burst(xfer_burst),
    .xfer_ecc(xfer_ecc), .xfer_count(xfer_count), .status(status),
    .int_raw(int_raw), .int_en(int_en), .irq(irq));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int idx, input int data);
    reg_wr = 6'(1 << idx); reg_wdata = CW'(data);
    tick();
    reg_wr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 run", xfer_run, 0);
    chk("R1 cfg", {xfer_dir, xfer_burst, xfer_ecc}, 0);
    chk("R1 count", xfer_count, 0);
    chk("R1 raw", int_raw, 0);
    chk("R1 en", int_en, 0);
    chk("R1 irq", irq, 0);

    // R5 status sweep
    for (int v = 0; v < 8; v++) begin
      {strm_fifo_nempty, byte_fifo_nempty, dev_ready} = 3'(v);
      #1 chk("R5 status", status, v);
    end
    dev_ready = 1'b0; strm_fifo_nempty = 1'b0; byte_fifo_nempty = 1'b0;
    tick(); tick();
    wr(5, 3);
    chk("R9 clear all", int_raw, 0);

    // R4 config sweep
    for (int v = 0; v < 32; v++) begin
      wr(1, v);
      chk("R4 cfg", {xfer_ecc, xfer_burst, xfer_dir}, ((v >> 4) & 1) * 4 + ((v >> 2) & 1) * 2 + ((v >> 1) & 1));
    end

    // R2/R6 count run-down sweep
    for (int n = 1; n <= 6; n++) begin
      wr(2, n);
      chk("R2 load", xfer_count, n);
      wr(0, 1);
      chk("R3 run set", xfer_run, 1);
      for (int k = 1; k <= n + 1; k++) begin
        byte_moved = 1'b1; tick(); byte_moved = 1'b0;
        chk("R2 step", xfer_count, (k >= n) ? 0 : n - k);
        chk("R6 done flag", int_raw[1], (k >= n) ? 1 : 0);
      end
      wr(0, 0);
      chk("R3 run clear", xfer_run, 0);
      wr(5, 2);
      chk("R9 clear done", int_raw, 0);
    end

    // R3 idle bytes ignored
    wr(2, 5);
    for (int k = 0; k < 4; k++) begin
      byte_moved = 1'b1; tick(); byte_moved = 1'b0;
      chk("R3 idle hold", xfer_count, 5);
    end
    // R3 stop mid-transfer
    wr(0, 1);
    byte_moved = 1'b1; tick(); byte_moved = 1'b0;
    chk("R3 running step", xfer_count, 4);
    wr(0, 0);
    byte_moved = 1'b1; tick(); byte_moved = 1'b0;
    chk("R3 stopped hold", xfer_count, 4);
    // R6 load zero while running gives no done
    wr(0, 1);
    wr(2, 0);
    tick();
    chk("R6 load zero", int_raw[1], 0);
    // R2 load beats step
    wr(2, 1);
    byte_moved = 1'b1; reg_wr = 6'b000100; reg_wdata = 9; tick(); reg_wr = '0; byte_moved = 1'b0;
    chk("R2 load priority", xfer_count, 9);
    chk("R6 no done on load", int_raw[1], 0);
    wr(0, 0);

    // R7 ready edge
    dev_ready = 1'b1; tick();
    chk("R7 rise", int_raw[0], 1);
    wr(5, 1);
    chk("R7 cleared", int_raw[0], 0);
    tick(); tick();
    chk("R7 level no retrigger", int_raw[0], 0);
    // R10 event with clear in same cycle
    dev_ready = 1'b0; tick();
    dev_ready = 1'b1; reg_wr = 6'b100000; reg_wdata = 1; tick(); reg_wr = '0;
    chk("R10 event beats clear", int_raw[0], 1);
    wr(5, 3);

    // R9 set/clear sweep
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < 4; d++) begin
        wr(5, 3); wr(4, p);
        wr(5, d);
        chk("R9 clear", int_raw, p & ~d & 3);
        wr(5, 3); wr(4, p);
        reg_wr = 6'b110000; reg_wdata = CW'(d); tick(); reg_wr = '0;
        chk("R9 set wins", int_raw, p | d);
      end
    end

    // R8 mask sweep
    for (int r = 0; r < 4; r++) begin
      for (int e = 0; e < 4; e++) begin
        wr(5, 3); wr(4, r); wr(3, e);
        chk("R8 en", int_en, e);
        chk("R8 irq", irq, ((r & e) != 0) ? 1 : 0);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule